// File: doc/BRIEF.md
# Remote Terminal Status Word Builder

This block assembles the 16-bit status word that a serial avionics bus remote terminal returns after each valid command addressed to it. It combines the terminal address, four level inputs from the subsystem (service request, busy, subsystem flag and terminal flag) and the state left by the message decoder. The decoder reports message errors and broadcast receptions as one-cycle pulses. The block latches these as event bits and holds them until the next valid command clears them.

The decoder also signals two terminal-flag mode codes: one inhibits the terminal flag and one overrides that inhibit. The inhibit state masks bit 0 of the word. The assembled word is loaded into an output register only when the encoder raises its status-start strobe. The word therefore stays still while it is being serialised, whatever the inputs do.

Top module: `rt_status_word`

## Requirements
- R1: After reset, `statusWord` is 0x0000, and both event bits and the inhibit state are cleared.
- R2: `statusWord` changes only on the clock edge at which `statusStart` is high. At that edge it takes `termAddr` in bits 15:11, `svcReq` in bit 8, `busyIn` in bit 3 and `subsysFlag` in bit 2, all sampled at that edge. At every other edge it holds its value.
- R3: Bits 9, 7:5 and 1 of a captured word are always 0.
- R4: A `msgErrPulse` sets the message-error event. Every later capture shows it as bit 10 = 1 until a clearing command.
- R5: A `bcastPulse` sets the broadcast event. Every later capture shows it as bit 4 = 1 until a clearing command.
- R6: A `cmdValidPulse` with `cmdKeepEvents` = 0 clears both event bits. If an event pulse arrives in the same cycle, that event is set.
- R7: A `cmdValidPulse` with `cmdKeepEvents` = 1 leaves both event bits unchanged. This case covers the transmit-status and transmit-last-command mode codes.
- R8: Bit 0 of a captured word equals `termFlag` when the inhibit state is clear, and is 0 when it is set.
- R9: `inhibitTfPulse` sets the inhibit state and `overrideTfPulse` clears it. When both arrive in the same cycle, the override wins.
- R10: The event and inhibit state used at a capture is the state registered before that edge. A pulse in the same cycle as `statusStart` shows only in the next capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| termAddr | input | 5 | Terminal address |
| svcReq | input | 1 | Service request level |
| busyIn | input | 1 | Busy level |
| subsysFlag | input | 1 | Subsystem flag level |
| termFlag | input | 1 | Terminal flag level |
| msgErrPulse | input | 1 | Message error detected (one cycle) |
| bcastPulse | input | 1 | Broadcast message received (one cycle) |
| cmdValidPulse | input | 1 | New valid command accepted (one cycle) |
| cmdKeepEvents | input | 1 | Qualifies cmdValidPulse: command must preserve event bits |
| inhibitTfPulse | input | 1 | Inhibit terminal flag mode code (one cycle) |
| overrideTfPulse | input | 1 | Override inhibit terminal flag mode code (one cycle) |
| statusStart | input | 1 | Encoder starts sending status; capture strobe |
| statusWord | output | 16 | Registered status word |

## Verification
The bench changes level inputs between captures and while no strobe is present. A design that updated the word continuously would show the change too early. It puts an event pulse and a clearing command in the same cycle, and pairs inhibit with override, so a wrong priority leaves a bit with the wrong value. A keep-events command checks that status-query mode codes do not wipe the error history. A pulse in the strobe cycle exposes a design that lets same-cycle events reach the word being sent.

// File: rtl/rt_sw_pkg.sv
package rt_sw_pkg;
  localparam int WORD_W = 16;
  localparam int ADDR_W = 5;
  localparam int ADDR_LSB = WORD_W - ADDR_W;
  localparam int BIT_MSGERR = 10;
  localparam int BIT_INSTR = 9;
  localparam int BIT_SVCREQ = 8;
  localparam int BIT_BCAST = 4;
  localparam int BIT_BUSY = 3;
  localparam int BIT_SUBSYS = 2;
  localparam int BIT_DYNBUS = 1;
  localparam int BIT_TFLAG = 0;

  typedef struct packed {
    logic clrEvents;
    logic setMsgErr;
    logic setBcast;
    logic inhSet;
    logic inhClr;
    logic capture;
  } swStrobes_t;
endpackage

// File: rtl/rt_sw_ctrl.sv
module rt_sw_ctrl
  import rt_sw_pkg::*;
(
  input  logic       msgErrPulse,
  input  logic       bcastPulse,
  input  logic       cmdValidPulse,
  input  logic       cmdKeepEvents,
  input  logic       inhibitTfPulse,
  input  logic       overrideTfPulse,
  input  logic       statusStart,
  output swStrobes_t strobes
);
  always_comb begin
    strobes = '0;
    strobes.clrEvents = cmdValidPulse & ~cmdKeepEvents;   // R6 / R7
    strobes.setMsgErr = msgErrPulse;
    strobes.setBcast  = bcastPulse;
    strobes.inhClr    = overrideTfPulse;                  // R9: override wins
    strobes.inhSet    = inhibitTfPulse & ~overrideTfPulse;
    strobes.capture   = statusStart;
  end
endmodule

// File: rtl/rt_sw_datapath.sv
module rt_sw_datapath
  import rt_sw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  swStrobes_t        strobes,
  input  logic [ADDR_W-1:0] termAddr,
  input  logic              svcReq,
  input  logic              busyIn,
  input  logic              subsysFlag,
  input  logic              termFlag,
  output logic [WORD_W-1:0] statusWord
);
  logic msgErrQ, bcastQ, inhibitQ;
  logic [WORD_W-1:0] nextWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      msgErrQ  <= 1'b0;
      bcastQ   <= 1'b0;
      inhibitQ <= 1'b0;
    end else begin
      msgErrQ  <= (msgErrQ & ~strobes.clrEvents) | strobes.setMsgErr;
      bcastQ   <= (bcastQ  & ~strobes.clrEvents) | strobes.setBcast;
      if (strobes.inhClr)      inhibitQ <= 1'b0;
      else if (strobes.inhSet) inhibitQ <= 1'b1;
    end
  end

  always_comb begin
    nextWord = '0;
    nextWord[WORD_W-1:ADDR_LSB] = termAddr;
    nextWord[BIT_MSGERR] = msgErrQ;
    nextWord[BIT_INSTR]  = 1'b0;
    nextWord[BIT_SVCREQ] = svcReq;
    nextWord[BIT_BCAST]  = bcastQ;
    nextWord[BIT_BUSY]   = busyIn;
    nextWord[BIT_SUBSYS] = subsysFlag;
    nextWord[BIT_DYNBUS] = 1'b0;
    nextWord[BIT_TFLAG]  = termFlag & ~inhibitQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                statusWord <= '0;
    else if (strobes.capture) statusWord <= nextWord;
  end

  // R4: a message error pulse always leaves the event latched
  a_r4_msgerr_latch: assert property (@(posedge clk) disable iff (!rstN)
    strobes.setMsgErr |=> msgErrQ);
  // R5: broadcast pulse latches
  a_r5_bcast_latch: assert property (@(posedge clk) disable iff (!rstN)
    strobes.setBcast |=> bcastQ);
  // R6: clearing command without a new event drops the message error
  a_r6_clear: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clrEvents && !strobes.setMsgErr) |=> !msgErrQ);
  // R2: word holds without a strobe
  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> $stable(statusWord));
  // R2: address captured at strobe
  a_r2_addr: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> statusWord[WORD_W-1:ADDR_LSB] == $past(termAddr));
  // R8: inhibited flag reads zero
  a_r8_inhibit: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && inhibitQ) |=> !statusWord[BIT_TFLAG]);
  // R9: override clears inhibit
  a_r9_override: assert property (@(posedge clk) disable iff (!rstN)
    strobes.inhClr |=> !inhibitQ);
endmodule

// File: rtl/rt_status_word.sv
module rt_status_word
  import rt_sw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] termAddr,
  input  logic              svcReq,
  input  logic              busyIn,
  input  logic              subsysFlag,
  input  logic              termFlag,
  input  logic              msgErrPulse,
  input  logic              bcastPulse,
  input  logic              cmdValidPulse,
  input  logic              cmdKeepEvents,
  input  logic              inhibitTfPulse,
  input  logic              overrideTfPulse,
  input  logic              statusStart,
  output logic [WORD_W-1:0] statusWord
);
  swStrobes_t strobes;

  rt_sw_ctrl u_ctrl (
    .msgErrPulse(msgErrPulse), .bcastPulse(bcastPulse),
    .cmdValidPulse(cmdValidPulse), .cmdKeepEvents(cmdKeepEvents),
    .inhibitTfPulse(inhibitTfPulse), .overrideTfPulse(overrideTfPulse),
    .statusStart(statusStart), .strobes(strobes)
  );

  rt_sw_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .termAddr(termAddr),
    .svcReq(svcReq), .busyIn(busyIn), .subsysFlag(subsysFlag),
    .termFlag(termFlag), .statusWord(statusWord)
  );
endmodule

// File: tb/rt_status_word_tb.sv
module rt_status_word_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [4:0] termAddr = '0;
  logic svcReq = 0, busyIn = 0, subsysFlag = 0, termFlag = 0;
  logic msgErrPulse = 0, bcastPulse = 0, cmdValidPulse = 0, cmdKeepEvents = 0;
  logic inhibitTfPulse = 0, overrideTfPulse = 0, statusStart = 0;
  logic [15:0] statusWord;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  rt_status_word u_dut (
    .clk(clk), .rstN(rstN), .termAddr(termAddr), .svcReq(svcReq),
    .busyIn(busyIn), .subsysFlag(subsysFlag), .termFlag(termFlag),
    .msgErrPulse(msgErrPulse), .bcastPulse(bcastPulse),
    .cmdValidPulse(cmdValidPulse), .cmdKeepEvents(cmdKeepEvents),
    .inhibitTfPulse(inhibitTfPulse), .overrideTfPulse(overrideTfPulse),
    .statusStart(statusStart), .statusWord(statusWord)
  );

  // Model of the field layout from the requirements
  function automatic logic [15:0] expWord(input logic [4:0] a, input logic me,
      input logic sr, input logic bc, input logic by, input logic ss, input logic tf);
    return {a, me, 1'b0, sr, 3'b000, bc, by, ss, 1'b0, tf};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Inputs change at negedge; one negedge-to-negedge window holds one posedge
  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: msgErrPulse = 1;
      1: bcastPulse = 1;
      2: begin cmdValidPulse = 1; cmdKeepEvents = 0; end
      3: begin cmdValidPulse = 1; cmdKeepEvents = 1; end
      4: inhibitTfPulse = 1;
      5: overrideTfPulse = 1;
      default: ;
    endcase
    @(negedge clk);
    msgErrPulse = 0; bcastPulse = 0; cmdValidPulse = 0; cmdKeepEvents = 0;
    inhibitTfPulse = 0; overrideTfPulse = 0;
  endtask

  task automatic capture();
    @(negedge clk); statusStart = 1;
    @(negedge clk); statusStart = 0;
  endtask

  task automatic setLevels(input logic [4:0] a, input logic sr, input logic by,
                           input logic ss, input logic tf);
    termAddr = a; svcReq = sr; busyIn = by; subsysFlag = ss; termFlag = tf;
  endtask

  task automatic t_reset();
    rstN = 0;
    repeat (3) @(negedge clk);
    check("R1 reset word", statusWord, 16'h0000);
    rstN = 1;
    capture();
    check("R1 events/inhibit clear", statusWord, expWord(5'd0,0,0,0,0,0,0));
  endtask

  task automatic t_fields();
    setLevels(5'h15, 1, 0, 1, 0);
    capture();
    check("R2/R3 fields A", statusWord, expWord(5'h15,0,1,0,0,1,0));
    setLevels(5'h0A, 0, 1, 0, 1);
    capture();
    check("R2/R3 fields B", statusWord, expWord(5'h0A,0,0,0,1,0,1));
    setLevels(5'h1F, 1, 1, 1, 1);
    repeat (3) @(negedge clk);
    check("R2 hold without strobe", statusWord, expWord(5'h0A,0,0,0,1,0,1));
    capture();
    check("R3 reserved zero all ones", statusWord, 16'hF90D);
  endtask

  task automatic t_events();
    setLevels(5'h03, 0, 0, 0, 0);
    pulse(0);
    capture();
    check("R4 msg err latched", statusWord, expWord(5'h03,1,0,0,0,0,0));
    capture();
    check("R4 msg err held", statusWord, expWord(5'h03,1,0,0,0,0,0));
    pulse(1);
    capture();
    check("R5 bcast latched", statusWord, expWord(5'h03,1,0,1,0,0,0));
    pulse(3);
    capture();
    check("R7 keep-events command", statusWord, expWord(5'h03,1,0,1,0,0,0));
    pulse(2);
    capture();
    check("R6 clearing command", statusWord, expWord(5'h03,0,0,0,0,0,0));
  endtask

  task automatic t_same_cycle();
    @(negedge clk); bcastPulse = 1; msgErrPulse = 1;
    @(negedge clk); bcastPulse = 0; msgErrPulse = 0;
    @(negedge clk); cmdValidPulse = 1; cmdKeepEvents = 0; bcastPulse = 1;
    @(negedge clk); cmdValidPulse = 0; bcastPulse = 0;
    capture();
    check("R6 event wins over clear", statusWord, expWord(5'h03,0,0,1,0,0,0));
    @(negedge clk); statusStart = 1; msgErrPulse = 1;
    @(negedge clk); statusStart = 0; msgErrPulse = 0;
    check("R10 same-cycle pulse not in word", statusWord, expWord(5'h03,0,0,1,0,0,0));
    capture();
    check("R10 pulse in next capture", statusWord, expWord(5'h03,1,0,1,0,0,0));
  endtask

  task automatic t_inhibit();
    setLevels(5'h11, 0, 0, 0, 1);
    capture();
    check("R8 flag passes", statusWord, expWord(5'h11,1,0,1,0,0,1));
    pulse(4);
    capture();
    check("R8 flag inhibited", statusWord, expWord(5'h11,1,0,1,0,0,0));
    pulse(5);
    capture();
    check("R9 override restores", statusWord, expWord(5'h11,1,0,1,0,0,1));
    @(negedge clk); inhibitTfPulse = 1; overrideTfPulse = 1;
    @(negedge clk); inhibitTfPulse = 0; overrideTfPulse = 0;
    capture();
    check("R9 override wins", statusWord, expWord(5'h11,1,0,1,0,0,1));
    pulse(4);
    rstN = 0;
    @(negedge clk);
    rstN = 1;
    capture();
    check("R1/R9 reset clears inhibit and events", statusWord, expWord(5'h11,0,0,0,0,0,1));
  endtask

  initial begin
    t_reset();
    t_fields();
    t_events();
    t_same_cycle();
    t_inhibit();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule